// File: doc/BRIEF.md
# Single-Slope PWM Timer with Two Compare Channels

This block is an up-counting timer that generates pulse-width-modulated waveforms. A clock divider picks the rate at which the counter advances. Each advance is one timer tick. The counter climbs from zero to its ceiling and then returns to zero, so every waveform period has the same number of ticks. Two compare channels watch the counter. Each one drives its own waveform pin according to a two-bit output mode.

The compare values come from register-style level inputs. Each channel copies its value into an active compare register only at the ceiling, so a change made partway through a period never produces a glitched pulse. The block raises a sticky wrap flag each time the counter reaches its ceiling, and a sticky match flag for each channel. Software clears a flag by pulsing the matching clear input.

A ceiling-select input replaces the fixed ceiling with channel A's active compare value. In that setting, channel A can toggle its pin on every match, which gives a square wave at 50% duty.

Top module: `fpwm_timer`

## Requirements
- R1: After reset, with the divider stopped, both waveform pins and all three flags read 0.
- R2: With the ceiling-select input low, the counter advances by one per tick from 0 to 255 and then returns to 0. A period is therefore 256 ticks. The wrap flag becomes 1 on the tick where the counter is at its ceiling, so with divide-by-1 the flag rises every 256 clocks.
- R3: The divider select `clk_sel` works as follows: 1 advances every clock, 2 every 8 clocks, 3 every 64, 4 every 256 and 5 every 1024. The values 0, 6 and 7 stop the counter, so no flag sets and the waveform pins hold their value.
- R4: Output mode 2 gives non-inverted PWM. The pin goes to 1 on the ceiling tick and to 0 on the tick where the counter equals the active compare value C. It is high for C+1 ticks per period. When a match and the ceiling fall on the same tick, the ceiling action wins, so C=255 gives a pin that is always 1.
- R5: Output mode 3 gives inverted PWM. The pin goes to 0 on the ceiling tick and to 1 on a match, so it is low for C+1 ticks per period. C=255 gives a pin that is always 0.
- R6: A compare value of 0 gives a pulse one tick wide in every period: high in mode 2, low in mode 3.
- R7: A change to a compare input takes effect only on the next ceiling tick. The period already running keeps the old value.
- R8: When `top_is_cmp_a` is 1, the ceiling is channel A's active compare value. Mode 1 on channel A then inverts pin A on every match. With C=0 this gives a toggle on every tick, and with C=5 a toggle every 6 ticks.
- R9: Mode 0 drives the pin to 0. Mode 1 also drives the pin to 0 on channel B, and on channel A while `top_is_cmp_a` is 0.
- R10: A channel's match flag becomes 1 on the tick where the counter equals that channel's active compare value. After a wrap tick, a compare value of 30 sets the flag 31 ticks later.
- R11: Pulsing one clear input for one clock returns only that flag to 0 and leaves the other two flags alone. If a set and a clear arrive on the same clock, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clk_sel | input | 3 | Divider select (see R3) |
| top_is_cmp_a | input | 1 | Use channel A's compare value as the ceiling; enables toggle mode on A |
| cmp_a_val | input | CNT_W (8) | Compare value for channel A, loaded at the ceiling |
| cmp_b_val | input | CNT_W (8) | Compare value for channel B, loaded at the ceiling |
| out_mode_a | input | 2 | Output mode of channel A |
| out_mode_b | input | 2 | Output mode of channel B |
| clr_ovf | input | 1 | Clears the wrap flag |
| clr_match_a | input | 1 | Clears the channel A match flag |
| clr_match_b | input | 1 | Clears the channel B match flag |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky wrap flag |
| match_a_flag | output | 1 | Sticky channel A match flag |
| match_b_flag | output | 1 | Sticky channel B match flag |

## Verification
The hardest behaviour to reach from the ports is the compare buffering. A new compare value has to arrive just after a ceiling tick, and the period already running must still use the old value. The stimulus first lines up with the period by clearing the wrap flag and waiting for it to rise again, which leaves the counter at zero. It then changes the compare input in that same cycle. It counts the high cycles in the rest of that period and then in the whole next period. The two counts tell the old value from the new one without any view of the counter. The intervals between flag events, measured in clocks, cover the divider ratios, the ceiling taken from channel A, and the timing of the match flag.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  typedef enum logic [1:0] {
    CM_OFF          = 2'd0,
    CM_TOGGLE       = 2'd1,
    CM_CLR_ON_MATCH = 2'd2,
    CM_SET_ON_MATCH = 2'd3
  } cmode_e;

  // log2 of the division ratio for a select code; 0 for codes that stop the counter
  function automatic int unsigned presc_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    presc_shift = 3;
      3'd3:    presc_shift = 6;
      3'd4:    presc_shift = 8;
      3'd5:    presc_shift = 10;
      default: presc_shift = 0;
    endcase
  endfunction

  function automatic logic presc_running(input logic [2:0] sel);
    presc_running = (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  import fpwm_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;
  logic             run;

  always_comb begin
    run   = presc_running(sel);
    mask  = PRE_W'((32'd1 << presc_shift(sel)) - 32'd1);
    tick  = run && ((pre_q & mask) == mask);
    pre_d = run ? pre_q + PRE_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R3

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wrap  = tick && (cnt == top_val);
    cnt_d = cnt;
    if (tick) cnt_d = wrap ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt != top_val)) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt == top_val)) |=> (cnt == '0)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R3

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel #(
  parameter int CNT_W      = 8,
  parameter bit HAS_TOGGLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic [1:0]       mode,
  input  logic             toggle_allow,
  output logic [CNT_W-1:0] cmp_act,
  output logic             match,
  output logic             wave
);
  import fpwm_pkg::*;

  cmode_e           cm;
  logic             tog_en;
  logic             connected;
  logic [CNT_W-1:0] cmp_d;
  logic             wave_d;

  assign cm = cmode_e'(mode);

  generate
    if (HAS_TOGGLE) begin : g_tog
      assign tog_en = toggle_allow && (cm == CM_TOGGLE);
      AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_en && match) |=> (wave != $past(wave))); // R8
    end else begin : g_no_tog
      assign tog_en = 1'b0;
    end
  endgenerate

  always_comb begin
    match     = tick && (cnt == cmp_act);
    connected = (cm == CM_CLR_ON_MATCH) || (cm == CM_SET_ON_MATCH) || tog_en;
    cmp_d     = wrap ? cmp_in : cmp_act;
    wave_d    = wave;
    if (!connected) begin
      wave_d = 1'b0;
    end else if (tog_en) begin
      if (match) wave_d = ~wave;
    end else if (cm == CM_CLR_ON_MATCH) begin
      if (wrap)       wave_d = 1'b1;
      else if (match) wave_d = 1'b0;
    end else begin
      if (wrap)       wave_d = 1'b0;
      else if (match) wave_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
      wave    <= 1'b0;
    end else begin
      cmp_act <= cmp_d;
      wave    <= wave_d;
    end
  end

  AST_CMP_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cmp_act)); // R7
  AST_WAVE_DISCONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !connected |=> !wave); // R9
  AST_NONINV_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cm == CM_CLR_ON_MATCH && !tog_en && wrap) |=> wave); // R4
  AST_INV_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cm == CM_SET_ON_MATCH && wrap) |=> !wave); // R5

endmodule

// File: rtl/fpwm_flags.sv
module fpwm_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  logic [N-1:0] q_d;

  always_comb q_d = set | (q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]); // R11
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]); // R11
  end

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic             top_is_cmp_a,
  input  logic [CNT_W-1:0] cmp_a_val,
  input  logic [CNT_W-1:0] cmp_b_val,
  input  logic [1:0]       out_mode_a,
  input  logic [1:0]       out_mode_b,
  input  logic             clr_ovf,
  input  logic             clr_match_a,
  input  logic             clr_match_b,
  output logic             wave_a,
  output logic             wave_b,
  output logic             ovf_flag,
  output logic             match_a_flag,
  output logic             match_b_flag
);
  localparam int NCH = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]                 rst_sync;
  logic                       rst_int_n;
  logic                       tick;
  logic                       wrap;
  logic [CNT_W-1:0]           cnt;
  logic [CNT_W-1:0]           top_val;
  logic [NCH-1:0][CNT_W-1:0]  cmp_in_arr;
  logic [NCH-1:0][CNT_W-1:0]  cmp_act_arr;
  logic [NCH-1:0][1:0]        mode_arr;
  logic [NCH-1:0]             match_arr;
  logic [NCH-1:0]             wave_arr;
  logic [NCH:0]               flag_set;
  logic [NCH:0]               flag_clr;
  logic [NCH:0]               flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign cmp_in_arr = {cmp_b_val, cmp_a_val};
  assign mode_arr   = {out_mode_b, out_mode_a};
  assign top_val    = top_is_cmp_a ? cmp_act_arr[0] : CNT_MAX;

  fpwm_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_int_n), .sel(clk_sel), .tick(tick)
  );

  fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .top_val(top_val),
    .cnt(cnt), .wrap(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fpwm_channel #(.CNT_W(CNT_W), .HAS_TOGGLE(c == 0)) u_ch (
      .clk(clk), .rst_n(rst_int_n), .tick(tick), .wrap(wrap), .cnt(cnt),
      .cmp_in(cmp_in_arr[c]), .mode(mode_arr[c]), .toggle_allow(top_is_cmp_a),
      .cmp_act(cmp_act_arr[c]), .match(match_arr[c]), .wave(wave_arr[c])
    );
  end

  assign flag_set = {match_arr[1], match_arr[0], wrap};
  assign flag_clr = {clr_match_b, clr_match_a, clr_ovf};

  fpwm_flags #(.N(NCH + 1)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .set(flag_set), .clr(flag_clr), .q(flag_q)
  );

  assign wave_a       = wave_arr[0];
  assign wave_b       = wave_arr[1];
  assign ovf_flag     = flag_q[0];
  assign match_a_flag = flag_q[1];
  assign match_b_flag = flag_q[2];

  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    wrap |=> ovf_flag); // R2
  AST_MATCH_A_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    match_arr[0] |=> match_a_flag); // R10
  AST_MATCH_B_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    match_arr[1] |=> match_b_flag); // R10

endmodule

// File: tb/fpwm_timer_bench.sv
`timescale 1ns/1ps
module fpwm_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic       top_is_cmp_a;
  logic [7:0] cmp_a_val, cmp_b_val;
  logic [1:0] out_mode_a, out_mode_b;
  logic       clr_ovf, clr_match_a, clr_match_b;
  logic       wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

  always #10 clk = ~clk;

  fpwm_timer u_fpwm_timer (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .top_is_cmp_a(top_is_cmp_a),
    .cmp_a_val(cmp_a_val), .cmp_b_val(cmp_b_val),
    .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
    .clr_ovf(clr_ovf), .clr_match_a(clr_match_a), .clr_match_b(clr_match_b),
    .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
    .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
  );

  typedef struct {
    string req;
    int    val;
  } item_t;

  item_t exp_q[$];
  int    act_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;

  // driver side: expected value pushed before the measurement
  task automatic expect_val(input string req, input int val);
    item_t it;
    it.req = req;
    it.val = val;
    exp_q.push_back(it);
  endtask

  task automatic observe(input int val);
    act_q.push_back(val);
  endtask

  // monitor: pops and compares
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e;
      int    a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_checks++;
      if (a != e.val) begin
        n_fail++;
        $display("FAIL %s actual=%0d expected=%0d", e.req, a, e.val);
      end
    end
  end

  function automatic logic flag_of(input int which);
    case (which)
      0:       flag_of = ovf_flag;
      1:       flag_of = match_a_flag;
      default: flag_of = match_b_flag;
    endcase
  endfunction

  task automatic drive_clr(input int which, input logic v);
    case (which)
      0:       clr_ovf     = v;
      1:       clr_match_a = v;
      default: clr_match_b = v;
    endcase
  endtask

  task automatic count_high(input bit chan_b, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if ((chan_b ? wave_b : wave_a) == 1'b1) h++;
    end
  endtask

  task automatic count_edges(input int n, output int t);
    logic prev;
    prev = wave_a;
    t = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wave_a != prev) t++;
      prev = wave_a;
    end
  endtask

  // leaves the bench at the negedge right after a wrap tick
  task automatic sync_ovf();
    drive_clr(0, 1'b1);
    @(negedge clk);
    drive_clr(0, 1'b0);
    while (!ovf_flag) @(negedge clk);
  endtask

  // clears a flag now and counts clocks until it is seen set again
  task automatic flag_interval(input int which, output int n);
    drive_clr(which, 1'b1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) drive_clr(which, 1'b0);
    end while (!flag_of(which) && n < 40000);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int v;
    logic wa_hold;
    rst_n = 1'b0; clk_sel = 3'd0; top_is_cmp_a = 1'b0;
    cmp_a_val = 8'd0; cmp_b_val = 8'd0; out_mode_a = 2'd0; out_mode_b = 2'd0;
    clr_ovf = 1'b0; clr_match_a = 1'b0; clr_match_b = 1'b0;
    settle(4);
    rst_n = 1'b1;
    settle(6);

    // R1 reset state
    expect_val("R1 wave_a", 0);       observe(wave_a);
    expect_val("R1 wave_b", 0);       observe(wave_b);
    expect_val("R1 flags", 0);        observe({ovf_flag, match_a_flag, match_b_flag});

    // R4 / R5 main PWM
    cmp_a_val = 8'd100; out_mode_a = 2'd2;
    cmp_b_val = 8'd30;  out_mode_b = 2'd3;
    clk_sel = 3'd1;
    settle(600);
    expect_val("R4 noninv high count C=100", 101); count_high(1'b0, 256, v); observe(v);
    expect_val("R5 inv high count C=30", 225);     count_high(1'b1, 256, v); observe(v);

    // R2 period
    sync_ovf();
    expect_val("R2 wrap interval div1", 256); flag_interval(0, v); observe(v);

    // R10 match flag timing
    sync_ovf();
    expect_val("R10 match_b after wrap", 31); flag_interval(2, v); observe(v);

    // R7 buffered compare
    sync_ovf();
    cmp_a_val = 8'd200;
    expect_val("R7 old value kept", 100); count_high(1'b0, 255, v); observe(v);
    expect_val("R7 new value next period", 201); count_high(1'b0, 256, v); observe(v);

    // R6 / R4 / R5 extremes
    cmp_a_val = 8'd0; cmp_b_val = 8'd0;
    settle(600);
    expect_val("R6 spike noninv", 1);  count_high(1'b0, 256, v); observe(v);
    expect_val("R6 spike inv", 255);   count_high(1'b1, 256, v); observe(v);
    cmp_a_val = 8'd255; cmp_b_val = 8'd255;
    settle(600);
    expect_val("R4 max constant high", 256); count_high(1'b0, 256, v); observe(v);
    expect_val("R5 max constant low", 0);    count_high(1'b1, 256, v); observe(v);

    // R9 disconnected / unsupported toggle
    cmp_a_val = 8'd100; cmp_b_val = 8'd100;
    out_mode_a = 2'd1; out_mode_b = 2'd1;
    settle(600);
    expect_val("R9 A toggle without ceiling select", 0); count_high(1'b0, 256, v); observe(v);
    expect_val("R9 B toggle unsupported", 0);            count_high(1'b1, 256, v); observe(v);
    out_mode_a = 2'd0;
    settle(10);
    expect_val("R9 A mode 0", 0); count_high(1'b0, 256, v); observe(v);

    // R8 toggle with ceiling from channel A
    out_mode_a = 2'd1; cmp_a_val = 8'd0; top_is_cmp_a = 1'b1;
    settle(600);
    expect_val("R8 toggle C=0 every tick", 64); count_edges(64, v); observe(v);
    cmp_a_val = 8'd5;
    settle(600);
    expect_val("R8 toggle C=5 edges", 20); count_edges(120, v); observe(v);
    sync_ovf();
    expect_val("R8 ceiling=C wrap interval", 6); flag_interval(0, v); observe(v);
    top_is_cmp_a = 1'b0; out_mode_a = 2'd2; cmp_a_val = 8'd100;
    settle(600);

    // R3 divider ratios
    clk_sel = 3'd2;
    sync_ovf();
    expect_val("R3 wrap interval div8", 2048); flag_interval(0, v); observe(v);
    clk_sel = 3'd3;
    sync_ovf();
    expect_val("R3 wrap interval div64", 16384); flag_interval(0, v); observe(v);

    // R11 clear isolation, R3 stop
    clk_sel = 3'd1;
    settle(600);
    clk_sel = 3'd0;
    settle(4);
    expect_val("R11 all flags set before clear", 7); observe({ovf_flag, match_a_flag, match_b_flag});
    drive_clr(0, 1'b1);
    @(negedge clk);
    drive_clr(0, 1'b0);
    @(negedge clk);
    expect_val("R11 only wrap flag cleared", 3); observe({ovf_flag, match_a_flag, match_b_flag});
    clr_match_a = 1'b1; clr_match_b = 1'b1;
    @(negedge clk);
    clr_match_a = 1'b0; clr_match_b = 1'b0;
    wa_hold = wave_a;
    settle(600);
    expect_val("R3 stopped: no flag sets", 0); observe({ovf_flag, match_a_flag, match_b_flag});
    expect_val("R3 stopped: wave_a holds", int'(wa_hold)); observe(int'(wave_a));
    clk_sel = 3'd7;
    settle(600);
    expect_val("R3 code 7 stops", 0); observe({ovf_flag, match_a_flag, match_b_flag});

    settle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule